// File: doc/BRIEF.md
# Subset Load/Store Processor Core

This block is a 32-bit processor that finishes one instruction in every clock cycle. It executes a fixed subset of a load/store instruction set. The subset covers register arithmetic, immediate arithmetic, signed compares, word loads and stores, equality branches, absolute jumps and a call/return pair. The block holds the program counter, a 32-entry register file, an arithmetic unit, immediate extension, next-address selection, and two small word arrays that serve as instruction store and data store.

Both word arrays are filled through a load port while the `run` input is low. With `run` low, the program counter and every architectural state element keep their values. Raising `run` lets the core fetch from address 0. A debug port is provided for inspection. It always shows the program counter, and it returns any register picked by `dbg_sel` in the same cycle.

Constants wider than 16 bits are built in two steps. An upper-immediate instruction sets the high half of a register. An OR-immediate on the same register then fills in the low half.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears all 32 registers.
- R2: With `load_en` high, `load_data` is written to the word at index `load_addr`. The target is the data store when `load_dmem` is 1 and the instruction store when it is 0. While `run` is low, the PC, the registers and the data store do not change, apart from load-port writes.
- R3: Opcode 0 with funct 32 writes rs+rt to rd, and funct 34 writes rs-rt to rd. Both wrap modulo 2^32.
- R4: Funct 42 (R format) and opcode 10 (I format, sign-extended immediate) write 1 to the destination when the first operand is less than the second as signed numbers, and 0 otherwise.
- R5: Register 0 always reads as zero. Any write to it is dropped.
- R6: Opcode 8 writes rs plus the sign-extended immediate to rt. Opcode 13 writes rs OR the zero-extended immediate to rt.
- R7: Opcode 15 writes the immediate into bits 31:16 of rt and zeros into bits 15:0. Followed by opcode 13 on the same register, it forms any 32-bit constant.
- R8: Opcode 35 (load) and opcode 43 (store) use the address rs plus the sign-extended offset. The word index is address bits [MEM_AW+1:2]. A load writes rt, and a store writes rt's value to the data store.
- R9: Opcode 4 (equal) and opcode 5 (not equal) compare rs with rt. When the branch is taken, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4. All other instructions advance the PC by 4 unless they jump.
- R10: Opcode 2 jumps to {PC+4 bits 31:28, 26-bit field, 2'b00}. Opcode 3 jumps the same way and also writes PC+4 into register 31.
- R11: Opcode 0 with funct 8 loads the PC from rs.
- R12: `dbg_pc` equals the current PC, and `dbg_rdata` equals the register chosen by `dbg_sel` in the same cycle.
- R13: An opcode or R-format funct outside the subset writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 = execute one instruction per cycle, 0 = hold state |
| load_en | input | 1 | Write strobe for the load port |
| load_dmem | input | 1 | Load target: 1 = data store, 0 = instruction store |
| load_addr | input | MEM_AW | Word index for the load port |
| load_data | input | 32 | Word written by the load port |
| dbg_sel | input | 5 | Register number shown on `dbg_rdata` |
| dbg_rdata | output | 32 | Value of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
The assertions assume that the load port and `run` are never used for the same data-store word in the same cycle. They also assume that the program counter and every load or store address stay word-aligned, since the two low bits are dropped. The stimulus loads both stores only while `run` is low. Every branch, jump and memory offset in the test program is word-aligned. The program ends in a branch-to-self, so the core stays at a known address while its registers are read back through the debug port.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int RAW   = $clog2(NREGS);

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_CALL  = 6'd3;
    localparam logic [5:0] OP_BREQ  = 6'd4;
    localparam logic [5:0] OP_BRNE  = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_UPPER = 6'd15;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_JREG = 6'd8;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SLT  = 6'd42;

    localparam logic [RAW-1:0] LINK_REG = RAW'(31);

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_OR, ALU_UPPER} alu_op_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_e;
    typedef enum logic [2:0] {NX_SEQ, NX_BEQ, NX_BNE, NX_JUMP, NX_JREG} next_e;

    typedef struct packed {
        logic    reg_we;
        dst_e    dst;
        wb_e     wb;
        alu_op_e alu;
        logic    use_imm;
        logic    imm_zero;
        logic    mem_we;
        next_e   nxt;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{reg_we: 1'b0, dst: DST_RT, wb: WB_ALU,
                                   alu: ALU_ADD, use_imm: 1'b0, imm_zero: 1'b0,
                                   mem_we: 1'b0, nxt: NX_SEQ};

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext16(input logic [15:0] v);
        return {{(XLEN-16){1'b0}}, v};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = CTRL_NOP;
        unique case (op)
            OP_RTYPE: begin
                ctrl.dst = DST_RD;
                case (funct)
                    FN_ADD:  begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_ADD; end
                    FN_SUB:  begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SUB; end
                    FN_SLT:  begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SLT; end
                    FN_JREG: ctrl.nxt = NX_JREG;
                    default: ctrl = CTRL_NOP;
                endcase
            end
            OP_ADDI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu = ALU_ADD;
            end
            OP_SLTI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu = ALU_SLT;
            end
            OP_ORI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zero = 1'b1;
                ctrl.alu = ALU_OR;
            end
            OP_UPPER: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zero = 1'b1;
                ctrl.alu = ALU_UPPER;
            end
            OP_LOAD: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.wb = WB_MEM;
            end
            OP_STORE: begin
                ctrl.use_imm = 1'b1; ctrl.mem_we = 1'b1;
            end
            OP_BREQ: ctrl.nxt = NX_BEQ;
            OP_BRNE: ctrl.nxt = NX_BNE;
            OP_JUMP: ctrl.nxt = NX_JUMP;
            OP_CALL: begin
                ctrl.nxt = NX_JUMP; ctrl.reg_we = 1'b1;
                ctrl.dst = DST_LINK; ctrl.wb = WB_LINK;
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_SLT:   y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
            ALU_OR:    y = a | b;
            ALU_UPPER: y = {b[15:0], 16'h0000};
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int N  = NREGS,
    parameter int W  = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];

    // R5: location 0 never holds anything but zero
    p_zero_hold_r5: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);

    // R5: a write to a nonzero register is visible on the next cycle
    p_write_seen_r3: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load_en,
    input  logic              load_dmem,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [XLEN-1:0]   load_data,
    input  logic [RAW-1:0]    dbg_sel,
    output logic [XLEN-1:0]   dbg_rdata,
    output logic [XLEN-1:0]   dbg_pc
);

    localparam int MEM_WORDS = 1 << MEM_AW;

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0] pc, pc_next, pc4;
    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;

    logic [RAW-1:0]  f_rs, f_rt, f_rd, w_addr;
    logic [15:0]     f_imm;
    logic [25:0]     f_target;

    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, ld_val, w_data;
    logic [XLEN-1:0] br_tgt, jmp_tgt;
    logic            w_en, rs_eq_rt;

    // fetch
    assign instr    = imem[pc[MEM_AW+1:2]];
    assign f_rs     = instr[25:21];
    assign f_rt     = instr[20:16];
    assign f_rd     = instr[15:11];
    assign f_imm    = instr[15:0];
    assign f_target = instr[25:0];

    sc_decode u_dec (
        .op    (instr[31:26]),
        .funct (instr[5:0]),
        .ctrl  (ctrl)
    );

    sc_regfile #(.N(NREGS), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (w_en),
        .waddr (w_addr),
        .wdata (w_data),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .ra3   (dbg_sel),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .rd3   (dbg_rdata)
    );

    // execute
    assign imm_ext = ctrl.imm_zero ? zext16(f_imm) : sext16(f_imm);
    assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

    sc_alu u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu),
        .y  (alu_y)
    );

    assign ld_val = dmem[alu_y[MEM_AW+1:2]];

    // write-back
    always_comb begin
        unique case (ctrl.dst)
            DST_RD:   w_addr = f_rd;
            DST_LINK: w_addr = LINK_REG;
            default:  w_addr = f_rt;
        endcase
        unique case (ctrl.wb)
            WB_MEM:  w_data = ld_val;
            WB_LINK: w_data = pc4;
            default: w_data = alu_y;
        endcase
    end
    assign w_en = run && ctrl.reg_we;

    // next address
    assign pc4      = pc + XLEN'(4);
    assign br_tgt   = pc4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc4[31:28], f_target, 2'b00};
    assign rs_eq_rt = (rs_val == rt_val);

    always_comb begin
        unique case (ctrl.nxt)
            NX_BEQ:  pc_next = rs_eq_rt  ? br_tgt : pc4;
            NX_BNE:  pc_next = !rs_eq_rt ? br_tgt : pc4;
            NX_JUMP: pc_next = jmp_tgt;
            NX_JREG: pc_next = rs_val;
            default: pc_next = pc4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      pc <= '0;
        else if (run) pc <= pc_next;
    end

    // stores
    always_ff @(posedge clk) begin
        if (load_en && !load_dmem) imem[load_addr] <= load_data;
    end

    always_ff @(posedge clk) begin
        if (load_en && load_dmem)         dmem[load_addr] <= load_data;
        else if (run && ctrl.mem_we)      dmem[alu_y[MEM_AW+1:2]] <= rt_val;
    end

    assign dbg_pc = pc;

    // R2: a halted core keeps its program counter
    p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(pc));

    // R9: a non-branching, non-jumping instruction steps by one word
    p_seq_step_r9: assert property (@(posedge clk) disable iff (rst)
        (run && ctrl.nxt == NX_SEQ) |=> pc == $past(pc) + XLEN'(4));

    // R8: a store never also claims a register write
    p_store_nowb_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_we |-> !ctrl.reg_we);

    // R13: no register write is requested without a defined operation
    p_nop_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == 6'd63) |-> (!ctrl.reg_we && !ctrl.mem_we && ctrl.nxt == NX_SEQ));

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
    import sc_pkg::*;

    localparam int MEM_AW = 6;
    localparam int RUN_CYCLES = 60;

    logic              clk = 1'b0;
    logic              rst, run, load_en, load_dmem;
    logic [MEM_AW-1:0] load_addr;
    logic [31:0]       load_data;
    logic [4:0]        dbg_sel;
    logic [31:0]       dbg_rdata, dbg_pc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sc_core #(.MEM_AW(MEM_AW)) dut_i (
        .clk(clk), .rst(rst), .run(run), .load_en(load_en),
        .load_dmem(load_dmem), .load_addr(load_addr), .load_data(load_data),
        .dbg_sel(dbg_sel), .dbg_rdata(dbg_rdata), .dbg_pc(dbg_pc)
    );

    typedef struct packed {
        logic [4:0]  rnum;
        logic [31:0] value;
        logic [7:0]  req;
    } expect_t;

    localparam int NEXP = 18;
    localparam expect_t EXPECTS [NEXP] = '{
        '{5'd1,  32'h1234ABCD, 8'd7},   // R7 upper + or constant
        '{5'd2,  32'hFFFFFFFB, 8'd6},   // R6 addi negative
        '{5'd3,  32'h00008000, 8'd6},   // R6 ori zero-extends
        '{5'd4,  32'h1234ABC8, 8'd3},   // R3 add
        '{5'd5,  32'hEDCB542E, 8'd3},   // R3 sub wraps
        '{5'd6,  32'd1,        8'd4},   // R4 slt true
        '{5'd7,  32'd0,        8'd4},   // R4 slt false
        '{5'd8,  32'd1,        8'd4},   // R4 slti negative imm
        '{5'd9,  32'd0,        8'd4},   // R4 slti false
        '{5'd0,  32'd0,        8'd5},   // R5 write to reg 0 dropped
        '{5'd10, 32'd16,       8'd6},   // R6 base register
        '{5'd11, 32'h1234ABCD, 8'd8},   // R8 store then load
        '{5'd12, 32'hCAFEF00D, 8'd8},   // R8 negative offset, load-port data
        '{5'd13, 32'd0,        8'd13},  // R13 undefined op, skipped paths (R9)
        '{5'd14, 32'd2,        8'd9},   // R9 not-taken branch falls through
        '{5'd15, 32'd9,        8'd11},  // R11 return lands after call
        '{5'd16, 32'h00000055, 8'd10},  // R10 call target executed
        '{5'd31, 32'd88,       8'd10}   // R10 link value
    };

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input int op, input int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic load_word(input bit to_d, input int idx, input logic [31:0] w);
        @(negedge clk);
        load_en = 1'b1; load_dmem = to_d; load_addr = MEM_AW'(idx); load_data = w;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic read_reg(input int r, output logic [31:0] v);
        dbg_sel = 5'(r);
        #1 v = dbg_rdata;
    endtask

    logic [31:0] prog [32];

    task automatic build_prog();
        for (int i = 0; i < 32; i++) prog[i] = 32'd0;
        prog[0]  = enc_i(15, 0, 1, 16'h1234);
        prog[1]  = enc_i(13, 1, 1, 16'hABCD);
        prog[2]  = enc_i(8, 0, 2, 16'hFFFB);
        prog[3]  = enc_i(13, 0, 3, 16'h8000);
        prog[4]  = enc_r(1, 2, 4, 32);
        prog[5]  = enc_r(2, 1, 5, 34);
        prog[6]  = enc_r(2, 3, 6, 42);
        prog[7]  = enc_r(3, 2, 7, 42);
        prog[8]  = enc_i(10, 2, 8, 16'hFFFC);
        prog[9]  = enc_i(10, 3, 9, 16'h0005);
        prog[10] = enc_i(8, 0, 0, 16'h0007);
        prog[11] = enc_i(8, 0, 10, 16'h0010);
        prog[12] = enc_i(43, 10, 1, 16'h0004);
        prog[13] = enc_i(35, 10, 11, 16'h0004);
        prog[14] = enc_i(35, 10, 12, 16'hFFF8);
        prog[15] = enc_i(4, 1, 11, 16'h0001);
        prog[16] = enc_i(8, 0, 13, 16'h0001);
        prog[17] = enc_i(5, 1, 11, 16'h0001);
        prog[18] = enc_i(8, 0, 14, 16'h0002);
        prog[19] = enc_i(5, 2, 0, 16'h0001);
        prog[20] = enc_i(8, 0, 13, 16'h0003);
        prog[21] = enc_j(3, 24);
        prog[22] = enc_i(8, 0, 15, 16'h0009);
        prog[23] = enc_j(2, 30);
        prog[24] = enc_i(63, 0, 13, 16'h0001);
        prog[25] = enc_i(8, 0, 16, 16'h0055);
        prog[26] = enc_r(31, 0, 0, 8);
        prog[27] = enc_i(8, 0, 13, 16'h0004);
        prog[28] = enc_i(8, 0, 13, 16'h0004);
        prog[29] = enc_i(8, 0, 13, 16'h0004);
        prog[30] = enc_i(4, 0, 0, 16'hFFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; run = 1'b0; load_en = 1'b0; load_dmem = 1'b0;
        load_addr = '0; load_data = '0; dbg_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pc after reset", dbg_pc, 32'd0);
        read_reg(5, v);
        check("R1 register cleared", v, 32'd0);

        // R2 preload while halted
        build_prog();
        for (int i = 0; i < 32; i++) load_word(1'b0, i, prog[i]);
        load_word(1'b1, 2, 32'hCAFEF00D);
        load_word(1'b1, 5, 32'h0);
        check("R2 pc held while loading", dbg_pc, 32'd0);
        read_reg(1, v);
        check("R2 registers held while halted", v, 32'd0);

        // run the program
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        check("R12 debug pc after one lui", dbg_pc, 32'd4);
        read_reg(1, v);
        check("R7 lui fills upper half only", v, 32'h12340000);
        repeat (RUN_CYCLES) @(negedge clk);
        run = 1'b0;
        check("R9 halt loop address", dbg_pc, 32'd120);
        repeat (3) @(negedge clk);
        check("R2 pc stable with run low", dbg_pc, 32'd120);

        // table walk of register results
        for (int k = 0; k < NEXP; k++) begin
            read_reg(int'(EXPECTS[k].rnum), v);
            checks++;
            if (v !== EXPECTS[k].value) begin
                errors++;
                $display("FAIL R%0d: reg %0d actual %08h expected %08h",
                         EXPECTS[k].req, EXPECTS[k].rnum, v, EXPECTS[k].value);
            end
        end

        // R5 debug read of register 0 after an attempted write
        read_reg(0, v);
        check("R5 reg 0 reads zero", v, 32'd0);

        // R1 reset again clears state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 pc after second reset", dbg_pc, 32'd0);
        read_reg(31, v);
        check("R1 link reg cleared", v, 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule